// File: doc/BRIEF.md
# Multiple-Transfer Address Sequencer

This block walks a 16-entry register list and issues one word address per cycle for a load-multiple or store-multiple transfer. A one-cycle start pulse captures a 32-bit base address, the register list, a two-bit addressing mode, a writeback flag and a load/store flag. The block then offers the transfers on a valid/ready handshake: each offer carries a word address and the register index to move. Indices always go from the lowest set bit to the highest, and addresses always go upward in steps of four bytes.

The addressing mode changes only where the sequence begins and which value is returned as the updated base. The lowest address depends on how many bits are set in the list. After the last accepted transfer, the block gives a one-cycle done pulse together with the updated base value. For a load whose list includes register 15, the final offer is flagged as a program-counter load. Moving the data, banking registers and restoring status are handled outside this block.

Top module: `xfer_addr_seq`

## Requirements
- R1: After reset, `xfer_valid_o`, `done_o`, `wb_valid_o` and `busy_o` are all low.
- R2: With `mode_i` = 0 (increment, address used before stepping), the first transfer address equals the base.
- R3: With `mode_i` = 1 (increment, step before use), the first transfer address is base + 4.
- R4: With `mode_i` = 2 (decrement, use before step), the first transfer address is base − 4·n + 4, where n is the number of set bits in `reglist_i`.
- R5: With `mode_i` = 3 (decrement, step before use), the first transfer address is base − 4·n.
- R6: Transfers are offered for the set bits of the list in ascending index order, one per accepted handshake. Each following address is the previous one plus 4, with 32-bit wraparound. `xfer_last_o` is high only on the final offer, and no offer follows it.
- R7: While `xfer_valid_o` is high and `xfer_ready_i` is low, the address and the register index hold their values and valid stays high.
- R8: `done_o` is high for exactly the one cycle after the final handshake. In that cycle `wb_valid_o` equals the captured writeback flag. When it is high, `wb_base_o` is base + 4·n for modes 0 and 1 and base − 4·n for modes 2 and 3.
- R9: `pc_load_o` is high on an offer only when the captured load flag is 1 and that offer is for register 15, which is then the final offer. For a store, or a list without bit 15, it stays low.
- R10: An empty list makes no offer. `done_o` pulses in the cycle after the start is captured, and `wb_base_o` equals the base.
- R11: A start pulse that arrives while `busy_o` is high is ignored. The running sequence keeps its addresses and indices, and no further offers follow its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture a new request when idle |
| base_i | input | 32 | Base byte address |
| reglist_i | input | 16 | Register list, bit i selects register i |
| mode_i | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| wback_i | input | 1 | Request the updated base value |
| load_i | input | 1 | 1 for load, 0 for store |
| busy_o | output | 1 | A request is in progress |
| xfer_valid_o | output | 1 | A transfer is offered |
| xfer_ready_i | input | 1 | The consumer accepts the offered transfer |
| xfer_addr_o | output | 32 | Word address of the offered transfer |
| xfer_reg_o | output | 4 | Register index of the offered transfer |
| xfer_last_o | output | 1 | The offered transfer is the final one |
| pc_load_o | output | 1 | The offered transfer loads register 15 |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | `wb_base_o` carries the updated base |
| wb_base_o | output | 32 | Updated base value |

## Verification
The main function is tried with sparse, dense (all sixteen registers), single-bit and empty lists across all four modes. This separates errors in the population count and errors in the start-address offset, because a wrong count moves only the two decrement modes while a wrong offset moves only the "before/after" pairs. Runs with the consumer stalling every other cycle are compared with runs where it is always ready, which separates the hold behaviour from the stepping. A base near the top of the address space checks the wraparound. A list that includes register 15 is issued both as a load and as a store, which shows whether the PC flag looks at the direction of the transfer.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/xfer_seq_plan.sv
module xfer_seq_plan
  import xfer_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4,
  localparam int CNT_W     = $clog2(LIST_W + 1)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic [1:0]        mode_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] new_base_o
);

  function automatic logic [CNT_W-1:0] count_bits(input logic [LIST_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LIST_W; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  function automatic logic [ADDR_W-1:0] span_bytes(input logic [CNT_W-1:0] n);
    return ADDR_W'(n) * ADDR_W'(WORD_BYTES);
  endfunction

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] step;
  addr_mode_e        mode;

  assign mode    = addr_mode_e'(mode_i);
  assign count_o = count_bits(list_i);
  assign span    = span_bytes(count_o);
  assign step    = ADDR_W'(WORD_BYTES);

  always_comb begin
    unique case (mode)
      AM_INC_AFTER:  first_addr_o = base_i;
      AM_INC_BEFORE: first_addr_o = base_i + step;
      AM_DEC_AFTER:  first_addr_o = base_i - span + step;
      default:       first_addr_o = base_i - span;
    endcase
  end

  assign new_base_o = mode_i[1] ? (base_i - span) : (base_i + span);

endmodule

// File: rtl/xfer_seq_pick.sv
module xfer_seq_pick #(
  parameter int LIST_W = 16,
  localparam int IDX_W = $clog2(LIST_W)
) (
  input  logic [LIST_W-1:0] mask_i,
  output logic [LIST_W-1:0] hot_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_o
);

  logic [LIST_W-1:0] below;

  for (genvar g = 0; g < LIST_W; g++) begin : g_hot
    if (g == 0) begin : g_first
      assign below[g] = 1'b0;
    end else begin : g_rest
      assign below[g] = below[g-1] | mask_i[g-1];
    end
    assign hot_o[g] = mask_i[g] & ~below[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < LIST_W; i++) begin
      if (hot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign last_o = (|mask_i) && ((mask_i & ~hot_o) == '0);

endmodule

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq
  import xfer_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(LIST_W),
  localparam int CNT_W     = $clog2(LIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] reglist_i,
  input  logic [1:0]        mode_i,
  input  logic              wback_i,
  input  logic              load_i,
  output logic              busy_o,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [IDX_W-1:0]  xfer_reg_o,
  output logic              xfer_last_o,
  output logic              pc_load_o,
  output logic              done_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_base_o
);

  seq_state_e        state_q;
  logic [LIST_W-1:0] mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wb_q;
  logic              wback_q;
  logic              load_q;

  logic [CNT_W-1:0]  plan_count;
  logic [ADDR_W-1:0] plan_first;
  logic [ADDR_W-1:0] plan_wb;
  logic [LIST_W-1:0] pick_hot;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_last;

  // named events for the checker
  logic seq_launch;
  logic hs_fire;
  logic seq_finish;

  xfer_seq_plan #(
    .ADDR_W(ADDR_W), .LIST_W(LIST_W), .WORD_BYTES(WORD_BYTES)
  ) u_plan (
    .base_i      (base_i),
    .list_i      (reglist_i),
    .mode_i      (mode_i),
    .count_o     (plan_count),
    .first_addr_o(plan_first),
    .new_base_o  (plan_wb)
  );

  xfer_seq_pick #(.LIST_W(LIST_W)) u_pick (
    .mask_i(mask_q),
    .hot_o (pick_hot),
    .idx_o (pick_idx),
    .last_o(pick_last)
  );

  assign seq_launch = (state_q == SQ_IDLE) && start_i;
  assign hs_fire    = xfer_valid_o && xfer_ready_i;
  assign seq_finish = hs_fire && pick_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      wback_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (seq_launch) begin
            mask_q  <= reglist_i;
            addr_q  <= plan_first;
            wb_q    <= plan_wb;
            wback_q <= wback_i;
            load_q  <= load_i;
            state_q <= (plan_count == '0) ? SQ_DONE : SQ_RUN;
          end
        end
        SQ_RUN: begin
          if (hs_fire) begin
            mask_q <= mask_q & ~pick_hot;
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            if (pick_last) state_q <= SQ_DONE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != SQ_IDLE);
  assign xfer_valid_o = (state_q == SQ_RUN);
  assign xfer_addr_o  = addr_q;
  assign xfer_reg_o   = pick_idx;
  assign xfer_last_o  = xfer_valid_o && pick_last;
  assign pc_load_o    = xfer_valid_o && load_q && pick_last && mask_q[LIST_W-1];
  assign done_o       = (state_q == SQ_DONE);
  assign wb_valid_o   = done_o && wback_q;
  assign wb_base_o    = wb_q;

endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int LIST_W     = 16,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(LIST_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              xfer_valid_o,
  input logic              xfer_ready_i,
  input logic [ADDR_W-1:0] xfer_addr_o,
  input logic [IDX_W-1:0]  xfer_reg_o,
  input logic              xfer_last_o,
  input logic              pc_load_o,
  input logic              done_o,
  input logic              wb_valid_o,
  input logic              hs_fire,
  input logic              seq_finish
);

  assert_valid_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o || done_o) |-> busy_o);

  assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fire && !xfer_last_o) |=>
      (xfer_valid_o && xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(WORD_BYTES)
       && xfer_reg_o > $past(xfer_reg_o)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_reg_o)));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> (done_o && !xfer_valid_o));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o);

  assert_pc_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> (xfer_valid_o && xfer_last_o && xfer_reg_o == IDX_W'(LIST_W - 1)));

endmodule

bind xfer_addr_seq xfer_seq_chk #(
  .ADDR_W(ADDR_W), .LIST_W(LIST_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .xfer_valid_o(xfer_valid_o),
  .xfer_ready_i(xfer_ready_i),
  .xfer_addr_o (xfer_addr_o),
  .xfer_reg_o  (xfer_reg_o),
  .xfer_last_o (xfer_last_o),
  .pc_load_o   (pc_load_o),
  .done_o      (done_o),
  .wb_valid_o  (wb_valid_o),
  .hs_fire     (hs_fire),
  .seq_finish  (seq_finish)
);

// File: tb/test_xfer_addr_seq.sv
`timescale 1ns/1ps
module test_xfer_addr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reglist_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wback_i = 1'b0;
  logic        load_i = 1'b0;
  logic        xfer_ready_i = 1'b0;
  logic        busy_o, xfer_valid_o, xfer_last_o, pc_load_o, done_o, wb_valid_o;
  logic [31:0] xfer_addr_o, wb_base_o;
  logic [3:0]  xfer_reg_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  xfer_addr_seq i_xfer_addr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .reglist_i(reglist_i), .mode_i(mode_i), .wback_i(wback_i), .load_i(load_i),
    .busy_o(busy_o), .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
    .xfer_addr_o(xfer_addr_o), .xfer_reg_o(xfer_reg_o), .xfer_last_o(xfer_last_o),
    .pc_load_o(pc_load_o), .done_o(done_o), .wb_valid_o(wb_valid_o),
    .wb_base_o(wb_base_o)
  );

  // {base, list, mode, writeback, load, stall}
  localparam logic [52:0] VEC [0:6] = '{
    {32'h0000_1000, 16'h00F0, 2'd0, 1'b1, 1'b0, 1'b0},
    {32'h0000_2000, 16'h8005, 2'd1, 1'b1, 1'b1, 1'b1},
    {32'h0000_3000, 16'h0111, 2'd2, 1'b1, 1'b0, 1'b0},
    {32'h0000_4000, 16'hFFFF, 2'd3, 1'b0, 1'b1, 1'b1},
    {32'h0000_0004, 16'h8000, 2'd3, 1'b1, 1'b0, 1'b0},
    {32'hFFFF_FFFC, 16'h0003, 2'd0, 1'b1, 1'b0, 1'b1},
    {32'h0000_0500, 16'h0000, 2'd1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_vec(input logic [52:0] v);
    logic [31:0] base, low, nb, exp_addr;
    logic [15:0] list;
    logic [1:0]  md;
    logic        wb, ld, stall;
    int          n, seen;
    bit          first;
    base = v[52:21]; list = v[20:5]; md = v[4:3];
    wb = v[2]; ld = v[1]; stall = v[0];
    n = $countones(list);
    low = md[1] ? base - 32'(4 * n) : base;
    if (md == 2'd1 || md == 2'd2) low = low + 32'd4;
    nb = md[1] ? base - 32'(4 * n) : base + 32'(4 * n);

    @(negedge clk);
    start_i = 1'b1; base_i = base; reglist_i = list; mode_i = md;
    wback_i = wb; load_i = ld; xfer_ready_i = !stall;
    @(negedge clk);
    start_i = 1'b0;
    exp_addr = low;
    seen = 0;
    first = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (list[i]) begin
        seen++;
        if (stall) begin
          xfer_ready_i = 1'b0;
          chk(xfer_valid_o === 1'b1, "R7", 32'(xfer_valid_o), 32'd1);
          @(negedge clk);
          chk(xfer_valid_o === 1'b1 && xfer_addr_o === exp_addr && xfer_reg_o === 4'(i),
              "R7", xfer_addr_o, exp_addr);
          xfer_ready_i = 1'b1;
        end
        chk(xfer_valid_o === 1'b1 && xfer_addr_o === exp_addr,
            first ? mode_req(md) : "R6", xfer_addr_o, exp_addr);
        chk(xfer_reg_o === 4'(i), "R6", 32'(xfer_reg_o), 32'(i));
        chk(xfer_last_o === (seen == n), "R6", 32'(xfer_last_o), 32'(seen == n));
        chk(pc_load_o === (ld && i == 15), "R9", 32'(pc_load_o), 32'(ld && i == 15));
        first = 1'b0;
        exp_addr = exp_addr + 32'd4;
        @(negedge clk);
      end
    end
    chk(done_o === 1'b1 && xfer_valid_o === 1'b0, n == 0 ? "R10" : "R8",
        32'(done_o), 32'd1);
    chk(wb_valid_o === wb, "R8", 32'(wb_valid_o), 32'(wb));
    if (wb) chk(wb_base_o === nb, n == 0 ? "R10" : "R8", wb_base_o, nb);
    @(negedge clk);
    chk(done_o === 1'b0 && xfer_valid_o === 1'b0 && busy_o === 1'b0, "R8",
        32'(done_o), 32'd0);
    xfer_ready_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(xfer_valid_o === 1'b0 && done_o === 1'b0 && busy_o === 1'b0 && wb_valid_o === 1'b0,
        "R1", {28'd0, xfer_valid_o, done_o, busy_o, wb_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(xfer_valid_o === 1'b0 && busy_o === 1'b0, "R1", 32'(busy_o), 32'd0);

    for (int k = 0; k < 7; k++) run_vec(VEC[k]);

    // R11: a start pulse during a running sequence has no effect
    @(negedge clk);
    start_i = 1'b1; base_i = 32'h100; reglist_i = 16'h0003; mode_i = 2'd0;
    wback_i = 1'b1; load_i = 1'b0; xfer_ready_i = 1'b0;
    @(negedge clk);
    base_i = 32'h900; reglist_i = 16'h8000; mode_i = 2'd3; load_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(xfer_addr_o === 32'h100 && xfer_reg_o === 4'd0, "R11", xfer_addr_o, 32'h100);
    xfer_ready_i = 1'b1;
    @(negedge clk);
    chk(xfer_addr_o === 32'h104 && xfer_reg_o === 4'd1 && pc_load_o === 1'b0,
        "R11", xfer_addr_o, 32'h104);
    @(negedge clk);
    chk(done_o === 1'b1 && wb_base_o === 32'h108, "R11", wb_base_o, 32'h108);
    @(negedge clk);
    chk(xfer_valid_o === 1'b0 && busy_o === 1'b0, "R11", 32'(xfer_valid_o), 32'd0);
    @(negedge clk);
    chk(xfer_valid_o === 1'b0 && done_o === 1'b0, "R11", 32'(done_o), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule